// File: doc/BRIEF.md
# RTC divider chain and periodic rate

This block is the prescaler of a legacy real-time clock. A 15-stage binary counter advances on a 32.768 kHz time-base enable and, in normal operation, wraps once per second, producing a one-second pulse for the timekeeping core that sits downstream. A programmable periodic tick is taken from one selected stage of that counter. A square-wave output toggles on each tick while its enable input is set.

A single 8-bit configuration register sets the behaviour. Bits [3:0] hold a rate select and bits [6:4] hold a chain mode. Bit 7 reads back an update-in-progress flag that a write cannot change. The chain mode either runs the counter normally, holds it in reset, or skips its lowest 5, 10 or 15 stages so that test can reach a wrap quickly. The oscillator, the calendar counters and the interrupt flags are outside this block.

Top module: `rtc_divider_top`

## Requirements
- R1: After synchronous reset, `cfg_rdata` reads 0x20 (rate 0000, mode 010, flag 0), the counter is zero, and `tick_o`, `sec_o`, `sqw_o` and `uip_o` are low.
- R2: A write stores `cfg_wdata[3:0]` as the rate and `cfg_wdata[6:4]` as the mode, and both read back on the next cycle. `cfg_wdata[7]` is ignored, and `cfg_rdata[7]` always shows the update-in-progress flag.
- R3: In mode 010 (and in the unused codes 000 and 001), each enable adds one to the counter. `sec_o` is high for one clock on the wrap, which comes 32768 enables after a counter value of zero and every 32768 enables after that.
- R4: Modes 110 and 111 hold the counter at half its range (0x4000). While held there is no `sec_o`, no `tick_o` and no update-in-progress. After a return to 010, the first `sec_o` comes exactly 16384 enables later.
- R5: Modes 011, 100 and 101 skip 5, 10 and 15 low stages, so `sec_o` repeats every 1024, 32 and 1 enables. A tap on a skipped stage gives no tick.
- R6: Rate 0000 produces no `tick_o` at all.
- R7: For rates 0011 to 1111, the tick taps counter stage rate−2 (stage 0 is the first divide-by-2) and fires when that stage goes from 0 to 1. The period is 2^(rate−1) enables, and the first tick after a zero counter comes after 2^(rate−2) enables.
- R8: Rates 0001 and 0010 behave exactly like rates 1000 and 1001 (periods of 128 and 256 enables).
- R9: `tick_o` is one clock wide. It is high in the cycle after the clock edge that samples the enable causing it.
- R10: `uip_o` is high while the counter is in its last 8 values before the wrap. It falls in the same cycle that `sec_o` rises.
- R11: While `sqw_en` is high, `sqw_o` toggles with each tick. On the cycle after `sqw_en` is low, `sqw_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | 32.768 kHz time-base enable, one clock per count |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback: {flag, mode, rate} |
| sqw_en | input | 1 | Square-wave output enable |
| tick_o | output | 1 | Periodic tick pulse |
| sec_o | output | 1 | One-second pulse |
| sqw_o | output | 1 | Square-wave output |
| uip_o | output | 1 | Update-in-progress flag |

## Verification
The assertions assume that reset is asserted from time zero and that all inputs are known at every clock edge. They also assume that a mode change reaches the chain one cycle after it appears on `cfg_rdata`, so every property about holding or wrapping requires the mode to be stable over the two cycles it compares. The stimulus drives inputs only on falling edges. It keeps `tb_en` low whenever it writes the register, then runs enables back to back so that full one-second wraps fit in the run. Tick periods are measured between consecutive ticks, so the phase left over from an earlier configuration never affects a check.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    typedef enum logic [2:0] {
        CM_ALT0   = 3'b000,
        CM_ALT1   = 3'b001,
        CM_NORMAL = 3'b010,
        CM_SKIP_A = 3'b011,
        CM_SKIP_B = 3'b100,
        CM_SKIP_C = 3'b101,
        CM_HOLD_A = 3'b110,
        CM_HOLD_B = 3'b111
    } chain_mode_e;

    // Field order matches the readback layout: mode in [6:4], rate in [3:0].
    typedef struct packed {
        chain_mode_e mode;
        logic [3:0]  rate;
    } rtc_cfg_t;

    localparam logic [3:0] RATE_OFF  = 4'd0;
    localparam rtc_cfg_t   CFG_RESET = '{mode: CM_NORMAL, rate: RATE_OFF};

    function automatic logic mode_is_hold(input chain_mode_e m);
        return (m == CM_HOLD_A) || (m == CM_HOLD_B);
    endfunction

    // Number of low counter stages skipped for a given mode.
    function automatic int unsigned skip_stages(input chain_mode_e m,
                                                input int unsigned stages);
        case (m)
            CM_SKIP_A: return stages / 3;
            CM_SKIP_B: return (2 * stages) / 3;
            CM_SKIP_C: return stages;
            default:   return 0;
        endcase
    endfunction

    // Counter stage tapped by a rate code; codes 1 and 2 alias codes 8 and 9.
    function automatic int unsigned tap_stage(input logic [3:0] rate);
        int unsigned r;
        r = {28'd0, rate};
        if (r < 3) return r + 5;
        return r - 2;
    endfunction

endpackage

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg
    import rtc_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [6:0] wdata,
    output rtc_cfg_t   cfg
);

    rtc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= rtc_cfg_t'(wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
    import rtc_div_pkg::*;
#(
    parameter int unsigned STAGES  = 15,
    parameter int unsigned UIP_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_en,
    input  chain_mode_e       mode,
    output logic [STAGES-1:0] cnt_o,
    output logic [STAGES-1:0] cnt_nxt_o,
    output logic              adv_o,
    output logic              sec_o,
    output logic              uip_o
);

    localparam int unsigned       SW        = STAGES + 1;
    localparam logic [STAGES-1:0] HALF      = STAGES'(1) << (STAGES - 1);
    localparam logic [STAGES-1:0] UIP_START = ~STAGES'(UIP_LEN - 1);

    logic [STAGES-1:0] cnt_q;
    logic [SW-1:0]     inc;
    logic [SW-1:0]     sum;
    logic              hold;
    logic              sec_q;

    always_comb begin
        hold = mode_is_hold(mode);
        inc  = SW'(1) << skip_stages(mode, STAGES);
        sum  = {1'b0, cnt_q} + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sec_q <= 1'b0;
        end else begin
            sec_q <= 1'b0;
            if (hold) begin
                cnt_q <= HALF;
            end else if (tb_en) begin
                cnt_q <= sum[STAGES-1:0];
                sec_q <= sum[STAGES];
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign cnt_nxt_o = sum[STAGES-1:0];
    assign adv_o     = tb_en && !hold;
    assign sec_o     = sec_q;
    assign uip_o     = !hold && (cnt_q >= UIP_START);

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
    import rtc_div_pkg::*;
#(
    parameter int unsigned STAGES = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rate,
    input  logic [STAGES-1:0] cnt,
    input  logic [STAGES-1:0] cnt_nxt,
    input  logic              adv,
    input  logic              sqw_en,
    output logic              tick_o,
    output logic              sqw_o
);

    logic [STAGES-1:0] rise;
    logic              sel;
    logic              tick_d;
    logic              tick_q;
    logic              sqw_q;
    int unsigned       tap;

    for (genvar s = 0; s < STAGES; s++) begin : g_rise
        assign rise[s] = ~cnt[s] & cnt_nxt[s];
    end

    always_comb begin
        tap = tap_stage(rate);
        sel = 1'b0;
        for (int unsigned k = 0; k < STAGES; k++) begin
            if (k == tap) sel = rise[k];
        end
        tick_d = adv && (rate != RATE_OFF) && sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
            sqw_q  <= 1'b0;
        end else begin
            tick_q <= tick_d;
            if (!sqw_en) begin
                sqw_q <= 1'b0;
            end else if (tick_d) begin
                sqw_q <= ~sqw_q;
            end
        end
    end

    assign tick_o = tick_q;
    assign sqw_o  = sqw_q;

endmodule

// File: rtl/rtc_divider_top.sv
module rtc_divider_top
    import rtc_div_pkg::*;
#(
    parameter int unsigned STAGES  = 15,
    parameter int unsigned UIP_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tb_en,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       sqw_en,
    output logic       tick_o,
    output logic       sec_o,
    output logic       sqw_o,
    output logic       uip_o
);

    rtc_cfg_t          cfg;
    logic [STAGES-1:0] cnt;
    logic [STAGES-1:0] cnt_nxt;
    logic              adv;
    logic              uip;
    logic              unused_wbit;

    assign unused_wbit = cfg_wdata[7];

    rtc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata[6:0]),
        .cfg   (cfg)
    );

    rtc_div_chain #(
        .STAGES  (STAGES),
        .UIP_LEN (UIP_LEN)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .tb_en     (tb_en),
        .mode      (cfg.mode),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .adv_o     (adv),
        .sec_o     (sec_o),
        .uip_o     (uip)
    );

    rtc_rate_tap #(
        .STAGES (STAGES)
    ) u_tap (
        .clk     (clk),
        .rst     (rst),
        .rate    (cfg.rate),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .adv     (adv),
        .sqw_en  (sqw_en),
        .tick_o  (tick_o),
        .sqw_o   (sqw_o)
    );

    assign uip_o     = uip;
    assign cfg_rdata = {uip, cfg.mode, cfg.rate};

endmodule

// File: rtl/rtc_divider_chk.sv
module rtc_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [6:0] wdata_lo,
    input logic [7:0] cfg_rdata,
    input logic       sqw_en,
    input logic       tick_o,
    input logic       sec_o,
    input logic       sqw_o,
    input logic       uip_o
);

    assert_cfg_store_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata[6:0] == $past(wdata_lo)));

    assert_sec_after_uip_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_o && $past(cfg_rdata[6:4]) == 3'b010) |-> $past(uip_o));

    assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rdata[6:5]) == 2'b11) |-> (!sec_o && !tick_o && !uip_o));

    assert_rate_off_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rdata[3:0]) == 4'd0) |-> !tick_o);

    assert_tick_single_R9: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    assert_uip_end_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[6:4] == 3'b010 && $past(cfg_rdata[6:4]) == 3'b010 && $fell(uip_o))
        |-> sec_o);

    assert_sqw_off_R11: assert property (@(posedge clk) disable iff (rst)
        !sqw_en |=> !sqw_o);

endmodule

bind rtc_divider_top rtc_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .wdata_lo  (cfg_wdata[6:0]),
    .cfg_rdata (cfg_rdata),
    .sqw_en    (sqw_en),
    .tick_o    (tick_o),
    .sec_o     (sec_o),
    .sqw_o     (sqw_o),
    .uip_o     (uip_o)
);

// File: tb/sim_rtc_divider_top.sv
module sim_rtc_divider_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tb_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       sqw_en = 1'b0;
    logic [7:0] cfg_rdata;
    logic       tick_o;
    logic       sec_o;
    logic       sqw_o;
    logic       uip_o;

    always #4 clk = ~clk;

    rtc_divider_top u0 (
        .clk       (clk),
        .rst       (rst),
        .tb_en     (tb_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sqw_en    (sqw_en),
        .tick_o    (tick_o),
        .sec_o     (sec_o),
        .sqw_o     (sqw_o),
        .uip_o     (uip_o)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint g;
    int     sec_n, tick_n, uip_n, sqw_flips;
    longint sec_last, sec_prev, tick_last, tick_prev, uip_first, uip_last;
    logic   sqw_prev;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic clr();
        g = 0; sec_n = 0; tick_n = 0; uip_n = 0; sqw_flips = 0;
        sec_last = -1; sec_prev = -1; tick_last = -1; tick_prev = -1;
        uip_first = -1; uip_last = -1; sqw_prev = sqw_o;
    endtask

    task automatic sample();
        if (sec_o) begin sec_n++; sec_prev = sec_last; sec_last = g; end
        if (tick_o) begin tick_n++; tick_prev = tick_last; tick_last = g; end
        if (uip_o) begin
            uip_n++;
            if (uip_first < 0) uip_first = g;
            uip_last = g;
        end
        if (sqw_o != sqw_prev) sqw_flips++;
        sqw_prev = sqw_o;
    endtask

    // n back-to-back enables; each sample follows the edge that consumed one.
    task automatic step(input int n);
        tb_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n - 1) tb_en = 1'b0;
            g++;
            sample();
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "rdata", cfg_rdata, 8'h20);
        check("R1", "outputs", {tick_o, sec_o, sqw_o, uip_o}, 0);

        // R2 bit 7 ignored on write
        wr(8'hAF);
        check("R2", "rdata after write", cfg_rdata, 8'h2F);

        // R3/R7/R10/R11 first second from zero, rate 1111, square wave on
        sqw_en = 1'b1;
        clr();
        step(32768);
        check("R3", "sec count", sec_n, 1);
        check("R3", "sec index", sec_last, 32768);
        check("R7", "tick count", tick_n, 2);
        check("R7", "first tick", tick_prev, 8192);
        check("R7", "second tick", tick_last, 24576);
        check("R10", "uip length", uip_n, 8);
        check("R10", "uip first", uip_first, 32760);
        check("R10", "uip last", uip_last, 32767);
        check("R11", "sqw toggles", sqw_flips, 2);
        check("R11", "sqw level", sqw_o, 0);

        // R3/R11 second wrap, square wave off
        sqw_en = 1'b0;
        clr();
        step(32768);
        check("R3", "sec index 2", sec_last, 32768);
        check("R11", "sqw toggles off", sqw_flips, 0);
        check("R11", "sqw low", sqw_o, 0);

        // R4 hold codes
        wr(8'h63);
        check("R2", "rdata hold", cfg_rdata, 8'h63);
        clr();
        step(2000);
        check("R4", "hold 110 sec", sec_n, 0);
        check("R4", "hold 110 tick", tick_n, 0);
        check("R4", "hold 110 uip", uip_n, 0);
        wr(8'h73);
        clr();
        step(500);
        check("R4", "hold 111 quiet", sec_n + tick_n + uip_n, 0);

        // R4/R9/R7 release to normal with rate 0011, counter at 0x4000
        wr(8'h23);
        clr();
        step(1);
        check("R9", "no tick after 1", tick_n, 0);
        step(1);
        check("R9", "tick after 2nd enable", tick_last, 2);
        repeat (3) begin
            @(negedge clk);
            check("R9", "tick width", tick_o, 0);
        end
        step(16382);
        check("R4", "first sec after release", sec_last, 16384);
        check("R4", "sec count after release", sec_n, 1);
        check("R7", "rate 3 count", tick_n, 4096);
        check("R7", "rate 3 period", tick_last - tick_prev, 4);

        // R7/R8 rate sweep
        for (int rs = 1; rs <= 13; rs++) begin
            longint per;
            if (rs == 3) continue;
            per = (rs < 3) ? (longint'(1) << (rs + 6)) : (longint'(1) << (rs - 1));
            wr({1'b0, 3'b010, 4'(rs)});
            clr();
            step(int'(3 * per));
            check(rs < 3 ? "R8" : "R7", $sformatf("rate %0d count", rs), tick_n, 3);
            check(rs < 3 ? "R8" : "R7", $sformatf("rate %0d period", rs),
                  tick_last - tick_prev, per);
        end

        // R6 rate off
        wr(8'h20);
        clr();
        step(4096);
        check("R6", "rate 0 ticks", tick_n, 0);

        // R5 skip modes
        wr(8'h33);
        clr();
        step(3072);
        check("R5", "skip5 count", sec_n, 3);
        check("R5", "skip5 period", sec_last - sec_prev, 1024);
        check("R5", "skip5 low tap", tick_n, 0);
        wr(8'h43);
        clr();
        step(96);
        check("R5", "skip10 count", sec_n, 3);
        check("R5", "skip10 period", sec_last - sec_prev, 32);
        wr(8'h53);
        clr();
        step(5);
        check("R5", "skip15 count", sec_n, 5);

        summary();
        $finish;
    end

endmodule